// File: doc/BRIEF.md
# Burst-Capable Strobe-Handshake Register Slave

This block is a small register file that a host reaches over an asynchronous, strobe-driven microprocessor bus of the 68k kind. Every bus input (address strobe, chip select, read/write direction and data strobe) passes through a synchroniser into a fast internal clock. All decisions are then made on clean edges in that domain. The host opens a burst by pulsing the address strobe low while chip select is low. The rising edge of the strobe fixes the starting register.

Each data-strobe cycle after that moves one byte, and no new address phase is needed. The block waits a configurable settling time and then pulls its data-acknowledge low. When the host releases the data strobe, a write stores the bus byte, a read ends, and the register pointer moves on by one. Returning chip select high closes the burst. The bidirectional data bus is brought out as separate input, output and output-enable signals. A combinational peek port lets a test environment read any register directly.

Top module: `mbus_burst_slave`

## Requirements
- R1: After reset, `dtack_n` is 1, `data_oe` is 0 and every register reads 0 through the peek port.
- R2: A rising edge on `as_n` while `cs_n` is low takes the low `log2(DEPTH)` bits of `addr` as the start register of a new burst. The address must stay valid for four clock cycles after the edge.
- R3: A data-strobe cycle with `rw` low (write) stores `data_i` into the current register when `ds_n` returns high after the acknowledge. `data_i` must stay valid for four clock cycles after that edge.
- R4: `dtack_n` goes low only after the synchronised data strobe has been low for `SETTLE_CYC` internal cycles, never within the first three cycles after `ds_n` falls.
- R5: Each completed data-strobe cycle in a burst moves the current register to the next index. The index wraps from `DEPTH-1` to 0. No new address-strobe edge is needed.
- R6: Once `ds_n` is seen high, `dtack_n` returns high and stays high until the next data-strobe cycle has settled.
- R7: While `cs_n` is high, the slave ignores the strobes: `dtack_n` stays high, no register changes and `data_oe` stays low. A burst ended this way needs a new address-strobe edge.
- R8: A data-strobe cycle with `rw` high (read) drives the current register on `data_o` with `data_oe` high. It uses the same acknowledge and stepping rules and leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| as_n | input | 1 | Address strobe, active low, latched on rising edge |
| cs_n | input | 1 | Chip select, active low |
| rw | input | 1 | Direction: 1 read, 0 write |
| ds_n | input | 1 | Data strobe, active low |
| addr | input | ADDR_W | Host address bus |
| data_i | input | DATA_W | Data bus, host to slave |
| data_o | output | DATA_W | Data bus, slave to host |
| data_oe | output | 1 | Output enable for `data_o` |
| dtack_n | output | 1 | Data acknowledge, active low |
| peek_idx | input | log2(DEPTH) | Register index for the peek port |
| peek_data | output | DATA_W | Contents of register `peek_idx` |

## Verification
The bound checker enforces these rules on every cycle:
- the acknowledge falls only after exactly `SETTLE_CYC` cycles of settling;
- a released strobe drops the acknowledge on the next cycle;
- every completed transfer advances the pointer by one;
- a write enable never coincides with read drive and always falls inside an acknowledged cycle;
- a high chip select clears both the acknowledge and the drive.

Only the bench scenarios can show which register a byte actually lands in and what value a read returns. This covers the start-address capture, wrap-around at the top of the array, mixed read and write bursts, and strobes ignored while deselected.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ARMED  = 2'd1,
      ST_SETTLE = 2'd2,
      ST_ACK    = 2'd3
   } bus_state_t;
endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
   parameter int W       = 4,
   parameter int STAGES  = 3,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] sync_q,
   output logic [W-1:0] prev_q
);
   if (STAGES < 3) begin : g_bad_stages
      $error("mbus_sync needs at least three stages");
   end

   logic [STAGES-1:0][W-1:0] pipe;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      pipe[s] <= RST_VAL;
         else if (s == 0) pipe[s] <= async_i;
         else             pipe[s] <= pipe[(s == 0) ? 0 : s-1];
      end
   end

   assign sync_q = pipe[STAGES-2];
   assign prev_q = pipe[STAGES-1];
endmodule

// File: rtl/mbus_regs.sv
module mbus_regs #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   input  logic [IDX_W-1:0]  pk_idx,
   output logic [DATA_W-1:0] pk_data
);
   logic [DEPTH-1:0][DATA_W-1:0] mem;

   for (genvar g = 0; g < DEPTH; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   mem[g] <= '0;
         else if (wr_en && (wr_idx == IDX_W'(g)))      mem[g] <= wr_data;
      end
   end

   assign rd_data = mem[rd_idx];
   assign pk_data = mem[pk_idx];
endmodule

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
   import mbus_pkg::*;
#(
   parameter int ADDR_W     = 11,
   parameter int IDX_W      = 4,
   parameter int SETTLE_CYC = 2,
   localparam int CNT_W     = $clog2(SETTLE_CYC + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              as_s,
   input  logic              as_p,
   input  logic              cs_s,
   input  logic              ds_s,
   input  logic              ds_p,
   input  logic              rw_s,
   input  logic [ADDR_W-1:0] addr,
   output bus_state_t        st,
   output logic [IDX_W-1:0]  ptr,
   output logic              wr_en,
   output logic              dtack_n,
   output logic              drive
);
   logic             as_rise, ds_fall, ds_rise, dir_rd;
   logic [CNT_W-1:0] cnt;

   assign as_rise = as_s & ~as_p;
   assign ds_fall = ~ds_s & ds_p;
   assign ds_rise = ds_s & ~ds_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         ptr    <= '0;
         cnt    <= '0;
         dir_rd <= 1'b0;
      end else if (cs_s) begin
         st <= ST_IDLE;
      end else begin
         unique case (st)
            ST_IDLE: if (as_rise) begin
               ptr <= addr[IDX_W-1:0];
               st  <= ST_ARMED;
            end
            ST_ARMED: begin
               if (as_rise) begin
                  ptr <= addr[IDX_W-1:0];
               end else if (ds_fall) begin
                  st     <= ST_SETTLE;
                  cnt    <= '0;
                  dir_rd <= rw_s;
               end
            end
            ST_SETTLE: begin
               if (ds_rise)                              st  <= ST_ARMED;
               else if (cnt == CNT_W'(SETTLE_CYC - 1))   st  <= ST_ACK;
               else                                      cnt <= cnt + 1'b1;
            end
            ST_ACK: if (ds_rise) begin
               ptr <= ptr + 1'b1;
               st  <= ST_ARMED;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign wr_en   = (st == ST_ACK) && ds_rise && !dir_rd && !cs_s;
   assign dtack_n = (st != ST_ACK);
   assign drive   = dir_rd && !ds_s && ((st == ST_SETTLE) || (st == ST_ACK));
endmodule

// File: rtl/mbus_burst_slave.sv
module mbus_burst_slave
   import mbus_pkg::*;
#(
   parameter int ADDR_W     = 11,
   parameter int DATA_W     = 8,
   parameter int DEPTH      = 16,
   parameter int SETTLE_CYC = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     as_n,
   input  logic                     cs_n,
   input  logic                     rw,
   input  logic                     ds_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [DATA_W-1:0]        data_i,
   output logic [DATA_W-1:0]        data_o,
   output logic                     data_oe,
   output logic                     dtack_n,
   input  logic [$clog2(DEPTH)-1:0] peek_idx,
   output logic [DATA_W-1:0]        peek_data
);
   localparam int IDX_W = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (IDX_W > ADDR_W) begin : g_bad_addr
      $error("DEPTH exceeds the address range");
   end
   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("SETTLE_CYC must be at least 1");
   end

   logic [3:0]       sq, sp;
   logic             as_s, as_p, cs_s, ds_s, ds_p, rw_s;
   bus_state_t       st;
   logic [IDX_W-1:0] ptr;
   logic             wr_en;

   mbus_sync #(.W(4), .STAGES(3), .RST_VAL(4'b1111)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({as_n, cs_n, ds_n, rw}),
      .sync_q  (sq),
      .prev_q  (sp)
   );

   assign {as_s, cs_s, ds_s, rw_s} = sq;
   assign as_p = sp[3];
   assign ds_p = sp[1];

   mbus_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SETTLE_CYC(SETTLE_CYC)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .as_s    (as_s),
      .as_p    (as_p),
      .cs_s    (cs_s),
      .ds_s    (ds_s),
      .ds_p    (ds_p),
      .rw_s    (rw_s),
      .addr    (addr),
      .st      (st),
      .ptr     (ptr),
      .wr_en   (wr_en),
      .dtack_n (dtack_n),
      .drive   (data_oe)
   );

   mbus_regs #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (ptr),
      .wr_data (data_i),
      .rd_idx  (ptr),
      .rd_data (data_o),
      .pk_idx  (peek_idx),
      .pk_data (peek_data)
   );
endmodule

// File: rtl/mbus_burst_checker.sv
module mbus_burst_checker
   import mbus_pkg::*;
#(
   parameter int IDX_W      = 4,
   parameter int SETTLE_CYC = 2
) (
   input logic             clk,
   input logic             rst_n,
   input bus_state_t       st,
   input logic             cs_s,
   input logic             ds_s,
   input logic             ds_p,
   input logic [IDX_W-1:0] ptr,
   input logic             wr_en,
   input logic             dtack_n,
   input logic             data_oe
);
   int unsigned settle_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                settle_run <= 0;
      else if (st == ST_SETTLE)  settle_run <= settle_run + 1;
      else                       settle_run <= 0;
   end

   // R4: acknowledge appears only after a full settling window
   assert_settle_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dtack_n) |-> ($past(settle_run) == SETTLE_CYC - 1));

   // R6: a released strobe drops the acknowledge next cycle
   assert_ack_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!dtack_n && ds_s && !ds_p && !cs_s) |=> dtack_n);

   // R5: a completed transfer steps the pointer by one
   assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ACK && ds_s && !ds_p && !cs_s) |=> (ptr == $past(ptr) + 1'b1));

   // R3: writes occur only at the end of an acknowledged cycle
   assert_write_in_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (!dtack_n && !data_oe));

   // R7: deselection clears acknowledge and drive
   assert_deselect_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> (dtack_n && !data_oe));

   // R8: read drive only inside an active cycle with the strobe low
   assert_drive_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |-> (!ds_s && !cs_s));
endmodule

bind mbus_burst_slave mbus_burst_checker #(.IDX_W(IDX_W), .SETTLE_CYC(SETTLE_CYC)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .st      (st),
   .cs_s    (cs_s),
   .ds_s    (ds_s),
   .ds_p    (ds_p),
   .ptr     (ptr),
   .wr_en   (wr_en),
   .dtack_n (dtack_n),
   .data_oe (data_oe)
);

// File: tb/mbus_burst_slave_test.sv
module mbus_burst_slave_test;
   localparam int AW = 11, DW = 8, DEPTH = 16, IW = 4;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          as_n = 1'b1, cs_n = 1'b1, rw = 1'b1, ds_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] data_i = '0;
   logic [DW-1:0] data_o, peek_data;
   logic          data_oe, dtack_n;
   logic [IW-1:0] peek_idx = '0;

   int checks = 0, fails = 0;
   logic [DW-1:0] mdl [DEPTH];
   int            mptr = 0;
   logic [DW-1:0] exp_q [$];
   bit            rd_seen = 0;

   always #5 clk = ~clk;

   mbus_burst_slave #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH), .SETTLE_CYC(2)) uut (
      .clk(clk), .rst_n(rst_n), .as_n(as_n), .cs_n(cs_n), .rw(rw), .ds_n(ds_n),
      .addr(addr), .data_i(data_i), .data_o(data_o), .data_oe(data_oe),
      .dtack_n(dtack_n), .peek_idx(peek_idx), .peek_data(peek_data));

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: pops expected read data when a read cycle is acknowledged
   always @(negedge clk) begin
      if (!dtack_n && data_oe && !rd_seen) begin
         rd_seen = 1;
         if (exp_q.size() == 0) check(0, "R8 unexpected read", data_o, 0);
         else begin
            logic [DW-1:0] e;
            e = exp_q.pop_front();
            check(data_o == e, "R8 read data", data_o, e);
         end
      end
      if (dtack_n) rd_seen = 0;
   end

   task automatic start_burst(logic [AW-1:0] a);
      @(negedge clk);
      cs_n = 0; as_n = 0; addr = a;
      repeat (3) @(negedge clk);
      as_n = 1;
      repeat (5) @(negedge clk);
      mptr = int'(a) % DEPTH;
   endtask

   task automatic end_burst();
      @(negedge clk);
      cs_n = 1;
      repeat (5) @(negedge clk);
   endtask

   task automatic xfer(bit is_rd, logic [DW-1:0] d);
      int n;
      @(negedge clk);
      rw = is_rd; data_i = d;
      if (is_rd) exp_q.push_back(mdl[mptr]);
      @(negedge clk);
      ds_n = 0;
      n = 0;
      while (dtack_n && n < 30) begin @(negedge clk); n++; end
      check(!dtack_n, "R4 acknowledge arrives", dtack_n, 0);
      check(n >= 3, "R4 acknowledge not early", n, 3);
      ds_n = 1;
      n = 0;
      while (!dtack_n && n < 30) begin @(negedge clk); n++; end
      check(dtack_n, "R6 acknowledge released", dtack_n, 1);
      repeat (4) @(negedge clk);
      check(dtack_n, "R6 acknowledge stays high", dtack_n, 1);
      if (!is_rd) mdl[mptr] = d;
      mptr = (mptr + 1) % DEPTH;
   endtask

   task automatic verify_regs(string req);
      for (int i = 0; i < DEPTH; i++) begin
         peek_idx = IW'(i);
         #1;
         check(peek_data == mdl[i], req, peek_data, mdl[i]);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
      repeat (3) @(negedge clk);
      check(dtack_n == 1, "R1 dtack_n idle", dtack_n, 1);
      check(data_oe == 0, "R1 data_oe idle", data_oe, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);
      verify_regs("R1 reset contents");

      // R2, R3, R5: write burst from index 3
      start_burst(11'h003);
      xfer(0, 8'hA1); xfer(0, 8'hB2); xfer(0, 8'hC3);
      end_burst();
      verify_regs("R3 R5 write burst");

      // R5 wrap: start near the top (index 14)
      start_burst(11'h7FE);
      xfer(0, 8'h5E); xfer(0, 8'h6F); xfer(0, 8'h70);
      end_burst();
      verify_regs("R5 wrap burst");

      // R8: read burst from index 3 including a zero register
      start_burst(11'h003);
      xfer(1, 8'h00); xfer(1, 8'h00); xfer(1, 8'h00); xfer(1, 8'h00);
      end_burst();
      verify_regs("R8 read leaves registers");
      check(exp_q.size() == 0, "R8 all reads seen", exp_q.size(), 0);

      // mixed read then write in one burst at index 14
      start_burst(11'h00E);
      xfer(1, 8'h00); xfer(0, 8'h99);
      end_burst();
      verify_regs("R8 R5 mixed burst");

      // R7: strobes while deselected are ignored
      @(negedge clk);
      rw = 0; data_i = 8'hEE; as_n = 0; addr = 11'h001;
      repeat (3) @(negedge clk);
      as_n = 1;
      repeat (2) @(negedge clk);
      ds_n = 0;
      begin
         bit seen = 0;
         for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (!dtack_n || data_oe) seen = 1;
         end
         check(!seen, "R7 no acknowledge when deselected", seen, 0);
      end
      ds_n = 1;
      repeat (6) @(negedge clk);
      verify_regs("R7 no write when deselected");

      // R2: new burst after deselect restarts at a new address
      start_burst(11'h108);
      xfer(0, 8'h42);
      end_burst();
      verify_regs("R2 new start address");

      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end
endmodule